// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line back into parallel words. The clock enable `tick16` pulses once per sub-bit, at `OVERSAMPLE` times the bit rate (16 by default). The receiver passes the line through a small synchronizer and waits for a falling edge. It confirms the start bit halfway through the bit and then samples each following bit at its centre. Word length, parity enable, parity sense and stick parity come from static configuration inputs. These inputs are captured when a start bit is detected, so a change during a frame does not affect the frame in progress.

A finished word is moved from the shift register into a holding register and `data_ready` is raised. The shift register is then free to assemble the next frame while the host still reads the previous one. Four status flags travel with the word: parity error, framing error, overrun and break. A single-cycle `rd_strobe` clears `data_ready` and all four flags. The held word stays where it is.

Top module: `serial_rx_frame`

## Requirements
- R1: `cfg_len` selects the word length: 0 gives 5 data bits, 1 gives 6, 2 gives 7 and 3 gives 8.
- R2: The first data bit after the start bit lands in `rx_data[0]`. Words shorter than 8 bits are right-justified and their unused upper bits read 0.
- R3: With `cfg_par_en`=1 and `cfg_par_stick`=0, one parity bit follows the data. `err_parity` is set when data and parity together hold an odd count of ones while `cfg_par_even`=1, or an even count while `cfg_par_even`=0.
- R4: With `cfg_par_en`=1 and `cfg_par_stick`=1, the parity bit is expected to equal the inverse of `cfg_par_even`. Any other value sets `err_parity`, whatever the data holds.
- R5: A low level is taken as a start bit only if the line is still low half a bit later. A shorter low pulse produces no word and no flag.
- R6: Only the first stop bit is sampled. A low first stop bit sets `err_frame`. A new start bit may follow one stop bit directly.
- R7: `err_overrun` is set when a word completes while `data_ready` is still 1 and no read is made in that cycle. The newer word replaces the held one.
- R8: `brk_det` is set when all data bits, the parity bit (if enabled) and the stop bit are all 0.
- R9: `data_ready` rises one cycle after a frame completes. `rx_data` changes only when a frame completes, so it holds the previous word while the next frame is being received.
- R10: `rd_strobe` clears `data_ready`, `err_parity`, `err_frame`, `err_overrun` and `brk_det` on the next edge, and leaves `rx_data` unchanged.
- R11: After reset, `rx_data` is 0 and every flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sub-bit clock enable, OVERSAMPLE pulses per bit |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Word length code (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_even | input | 1 | Even parity when 1, odd when 0 |
| cfg_par_stick | input | 1 | Parity bit fixed to the inverse of cfg_par_even |
| rd_strobe | input | 1 | Host read: clears ready and flags |
| rx_data | output | 8 | Held received word, right-justified |
| data_ready | output | 1 | A word is waiting in rx_data |
| err_parity | output | 1 | Parity mismatch on a held word |
| err_frame | output | 1 | First stop bit was low |
| err_overrun | output | 1 | A word arrived before the previous one was read |
| brk_det | output | 1 | An all-zero frame was seen |

## Verification
The bench sends frames of every word length with even, odd and stick parity. Each frame uses a data pattern whose upper bits would show a justification slip or a reversed bit order as a wrong value. It corrupts parity bits and stop bits on purpose: a checker that inverted the parity sense, or ignored the stick rule, would flag good frames or pass bad ones. A short low glitch must give no word, which catches a receiver that commits to a start bit on the falling edge alone. Frames sent back to back with a single stop bit would be lost if the second stop bit were checked. A frame held unread while the next one arrives must keep the old word visible mid-frame and then report overrun, which catches a single-buffered design or one that never sets the flag.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   localparam int WORD_W   = 8;
   localparam int MIN_BITS = 5;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_PAR,
      RX_STOP
   } rx_state_t;

   typedef struct packed {
      logic [WORD_W-1:0] word;
      logic              par_err;
      logic              frm_err;
      logic              brk;
   } rx_result_t;

   // number of data bits minus one for a length code
   function automatic logic [2:0] last_index(input logic [1:0] len_code);
      return 3'(MIN_BITS - 1) + {1'b0, len_code};
   endfunction

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign dout = din;
      end else begin : g_chain
         logic [STAGES-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '1;
            end else begin
               q[0] <= din;
               for (int i = 1; i < STAGES; i++) begin
                  q[i] <= q[i-1];
               end
            end
         end
         assign dout = q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler
   import serial_rx_pkg::*;
#(
   parameter int OVERSAMPLE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   input  logic       cfg_par_stick,
   output logic       done,
   output rx_result_t result
);

   localparam int CW   = $clog2(OVERSAMPLE);
   localparam int HALF = OVERSAMPLE / 2;
   localparam logic [CW-1:0] FULL_END = CW'(OVERSAMPLE - 1);
   localparam logic [CW-1:0] HALF_END = CW'(HALF - 1);

   rx_state_t         state;
   logic [CW-1:0]     tcnt;
   logic [2:0]        bidx;
   logic [WORD_W-1:0] shreg;
   logic              pbit;
   logic [1:0]        len_q;
   logic              pen_q, even_q, stick_q;

   logic              at_centre;
   logic              at_half;
   logic [WORD_W-1:0] word_just;
   logic              par_bad;
   logic              brk_seen;

   assign at_centre = (tcnt == FULL_END);
   assign at_half   = (tcnt == HALF_END);

   // bits enter from the top, so a short word sits high: shift it down
   assign word_just = shreg >> (2'd3 - len_q);

   always_comb begin
      if (!pen_q) begin
         par_bad = 1'b0;
      end else if (stick_q) begin
         par_bad = (pbit != !even_q);
      end else begin
         par_bad = ((^word_just) ^ pbit) != !even_q;
      end
   end

   assign brk_seen = (word_just == '0) && (!pen_q || !pbit) && !line;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         tcnt    <= '0;
         bidx    <= '0;
         shreg   <= '0;
         pbit    <= 1'b0;
         len_q   <= '0;
         pen_q   <= 1'b0;
         even_q  <= 1'b0;
         stick_q <= 1'b0;
         done    <= 1'b0;
         result  <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!line) begin
                     state   <= RX_START;
                     tcnt    <= '0;
                     bidx    <= '0;
                     shreg   <= '0;
                     len_q   <= cfg_len;
                     pen_q   <= cfg_par_en;
                     even_q  <= cfg_par_even;
                     stick_q <= cfg_par_stick;
                  end
               end
               RX_START: begin
                  if (at_half) begin
                     tcnt  <= '0;
                     state <= line ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (at_centre) begin
                     tcnt  <= '0;
                     shreg <= {line, shreg[WORD_W-1:1]};
                     bidx  <= bidx + 1'b1;
                     if (bidx == last_index(len_q)) begin
                        state <= pen_q ? RX_PAR : RX_STOP;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_PAR: begin
                  if (at_centre) begin
                     tcnt  <= '0;
                     pbit  <= line;
                     state <= RX_STOP;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (at_centre) begin
                     tcnt           <= '0;
                     state          <= RX_IDLE;
                     done           <= 1'b1;
                     result.word    <= word_just;
                     result.par_err <= par_bad;
                     result.frm_err <= !line;
                     result.brk     <= brk_seen;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/serial_rx_holdreg.sv
module serial_rx_holdreg
   import serial_rx_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  rx_result_t        incoming,
   input  logic              rd_strobe,
   output logic [WORD_W-1:0] rx_data,
   output logic              data_ready,
   output logic              err_parity,
   output logic              err_frame,
   output logic              err_overrun,
   output logic              brk_det
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data     <= '0;
         data_ready  <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
         brk_det     <= 1'b0;
      end else if (load) begin
         // a read in the same cycle retires the old word first
         rx_data     <= incoming.word;
         data_ready  <= 1'b1;
         err_parity  <= (err_parity  & !rd_strobe) | incoming.par_err;
         err_frame   <= (err_frame   & !rd_strobe) | incoming.frm_err;
         brk_det     <= (brk_det     & !rd_strobe) | incoming.brk;
         err_overrun <= (err_overrun | data_ready) & !rd_strobe;
      end else if (rd_strobe) begin
         data_ready  <= 1'b0;
         err_parity  <= 1'b0;
         err_frame   <= 1'b0;
         err_overrun <= 1'b0;
         brk_det     <= 1'b0;
      end
   end

endmodule

// File: rtl/serial_rx_frame.sv
module serial_rx_frame
   import serial_rx_pkg::*;
#(
   parameter int OVERSAMPLE  = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rxd,
   input  logic [1:0] cfg_len,
   input  logic       cfg_par_en,
   input  logic       cfg_par_even,
   input  logic       cfg_par_stick,
   input  logic       rd_strobe,
   output logic [7:0] rx_data,
   output logic       data_ready,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_overrun,
   output logic       brk_det
);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_ovs
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be in 0..4");
      end
      if (WORD_W != 8) begin : g_bad_word
         $error("word register must be 8 bits wide");
      end
   endgenerate

   logic       line_s;
   logic       frame_done;
   rx_result_t frame_res;

   serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rxd),
      .dout  (line_s)
   );

   serial_rx_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick          (tick16),
      .line          (line_s),
      .cfg_len       (cfg_len),
      .cfg_par_en    (cfg_par_en),
      .cfg_par_even  (cfg_par_even),
      .cfg_par_stick (cfg_par_stick),
      .done          (frame_done),
      .result        (frame_res)
   );

   serial_rx_holdreg u_hold (
      .clk         (clk),
      .rst_n       (rst_n),
      .load        (frame_done),
      .incoming    (frame_res),
      .rd_strobe   (rd_strobe),
      .rx_data     (rx_data),
      .data_ready  (data_ready),
      .err_parity  (err_parity),
      .err_frame   (err_frame),
      .err_overrun (err_overrun),
      .brk_det     (brk_det)
   );

endmodule

// File: rtl/serial_rx_frame_chk.sv
module serial_rx_frame_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       frame_done,
   input logic       rd_strobe,
   input logic [7:0] rx_data,
   input logic       data_ready,
   input logic       err_parity,
   input logic       err_frame,
   input logic       err_overrun,
   input logic       brk_det
);

   // R9: a completed frame is always presented
   p_ready_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> data_ready);

   // R9: the held word only moves when a frame completes
   p_word_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(rx_data));

   // R10: a read with no arriving frame empties the register
   p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_strobe && !frame_done) |=>
         !data_ready && !err_parity && !err_frame && !err_overrun && !brk_det);

   // R10: no status flag outlives the word it belongs to
   p_flags_need_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_parity || err_frame || err_overrun || brk_det) |-> data_ready);

   // R7: arrival over an unread word reports overrun
   p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && data_ready && !rd_strobe) |=> err_overrun);

   // R8: a break always carries a low stop bit
   p_break_has_frame_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      brk_det |-> err_frame);

endmodule

bind serial_rx_frame serial_rx_frame_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_done  (frame_done),
   .rd_strobe   (rd_strobe),
   .rx_data     (rx_data),
   .data_ready  (data_ready),
   .err_parity  (err_parity),
   .err_frame   (err_frame),
   .err_overrun (err_overrun),
   .brk_det     (brk_det)
);

// File: tb/serial_rx_frame_bench.sv
module serial_rx_frame_bench;

   localparam int TICK_DIV = 4;
   localparam int BIT_CLKS = TICK_DIV * 16;

   typedef struct packed {
      logic [7:0] d;
      logic       pe;
      logic       fe;
      logic       bk;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_even = 1'b0;
   logic       cfg_par_stick = 1'b0;
   logic       rd_strobe = 1'b0;
   logic [7:0] rx_data;
   logic       data_ready, err_parity, err_frame, err_overrun, brk_det;

   int   n_checks = 0;
   int   n_fail = 0;
   bit   auto_read = 1'b1;
   bit   finished = 1'b0;
   exp_t exp_q[$];

   serial_rx_frame u_serial_rx_frame (
      .clk           (clk),
      .rst_n         (rst_n),
      .tick16        (tick16),
      .rxd           (rxd),
      .cfg_len       (cfg_len),
      .cfg_par_en    (cfg_par_en),
      .cfg_par_even  (cfg_par_even),
      .cfg_par_stick (cfg_par_stick),
      .rd_strobe     (rd_strobe),
      .rx_data       (rx_data),
      .data_ready    (data_ready),
      .err_parity    (err_parity),
      .err_frame     (err_frame),
      .err_overrun   (err_overrun),
      .brk_det       (brk_det)
   );

   always #5 clk = ~clk;

   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         cnt    = (cnt + 1) % TICK_DIV;
         tick16 = (cnt == 0);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // driver: pushes the expected result, then drives the frame
   task automatic send_frame(input logic [7:0] d, input logic [1:0] len,
                             input logic pe, input logic even, input logic stick,
                             input logic flip_par, input logic stop_bit,
                             input int gap_bits, input bit push);
      int         nb;
      logic [7:0] m;
      logic       p;
      exp_t       e;
      nb = 5 + len;
      m  = d & 8'((1 << nb) - 1);
      p  = stick ? !even : (even ? ^m : !(^m));
      p  = p ^ flip_par;
      e.d  = m;
      e.pe = pe & flip_par;
      e.fe = !stop_bit;
      e.bk = (m == 8'h00) && (!pe || !p) && !stop_bit;
      cfg_len = len; cfg_par_en = pe; cfg_par_even = even; cfg_par_stick = stick;
      if (push) exp_q.push_back(e);
      rxd = 1'b0;
      repeat (BIT_CLKS) @(negedge clk);
      for (int i = 0; i < nb; i++) begin
         rxd = m[i];
         repeat (BIT_CLKS) @(negedge clk);
      end
      if (pe) begin
         rxd = p;
         repeat (BIT_CLKS) @(negedge clk);
      end
      rxd = stop_bit;
      repeat (BIT_CLKS) @(negedge clk);
      rxd = 1'b1;
      repeat (gap_bits * BIT_CLKS) @(negedge clk);
   endtask

   // monitor: pops the expectation when a word shows up, then reads it
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (auto_read && data_ready) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5 unexpected word", int'(rx_data), 0);
            end else begin
               e = exp_q.pop_front();
               chk(rx_data == e.d, "R1/R2 data word", int'(rx_data), int'(e.d));
               chk(err_parity == e.pe, "R3/R4 parity flag", int'(err_parity), int'(e.pe));
               chk(err_frame == e.fe, "R6 framing flag", int'(err_frame), int'(e.fe));
               chk(brk_det == e.bk, "R8 break flag", int'(brk_det), int'(e.bk));
               chk(err_overrun == 1'b0, "R7 no overrun", int'(err_overrun), 0);
            end
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            chk(!data_ready && !err_parity && !err_frame && !brk_det,
                "R10 read clears", int'({data_ready, err_parity, err_frame, brk_det}), 0);
         end
      end
   end

   initial begin
      repeat (200000) @(negedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      // R11 reset state
      chk(rx_data == 8'h00, "R11 reset data", int'(rx_data), 0);
      chk({data_ready, err_parity, err_frame, err_overrun, brk_det} == 5'b0,
          "R11 reset flags", int'({data_ready, err_parity, err_frame, err_overrun, brk_det}), 0);
      rst_n = 1'b1;
      repeat (3 * BIT_CLKS) @(negedge clk);

      // R1 / R2: each length, no parity, patterns with set upper bits
      send_frame(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'hEA, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'h9B, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'h01, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);

      // R3: even and odd, good and corrupted
      send_frame(8'h37, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'h37, 2'd3, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 2, 1'b1);
      send_frame(8'h16, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'h0D, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b1);

      // R4: stick parity both senses, good and wrong bit
      send_frame(8'h5C, 2'd3, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'h5D, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2, 1'b1);
      send_frame(8'h21, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2, 1'b1);

      // R6: bad stop bit, then back-to-back frames with one stop bit
      send_frame(8'h6B, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b1);
      send_frame(8'hC3, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 0, 1'b1);
      send_frame(8'h3C, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2, 1'b1);

      // R8: break, with and without parity
      send_frame(8'h00, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2, 1'b1);
      send_frame(8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2, 1'b1);

      // R5: short low glitch gives nothing
      rxd = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk);
      rxd = 1'b1;
      repeat (12 * BIT_CLKS) @(negedge clk);
      chk(data_ready == 1'b0, "R5 glitch rejected", int'(data_ready), 0);

      // R9 / R7 / R10: hold, double buffer, overrun
      auto_read = 1'b0;
      send_frame(8'h4E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b0);
      chk(data_ready == 1'b1, "R9 ready set", int'(data_ready), 1);
      chk(rx_data == 8'h4E, "R9 first word", int'(rx_data), 8'h4E);
      fork
         send_frame(8'hB1, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1, 1'b0);
         begin
            repeat (5 * BIT_CLKS) @(negedge clk);
            chk(rx_data == 8'h4E, "R9 old word held mid-frame", int'(rx_data), 8'h4E);
         end
      join
      chk(rx_data == 8'hB1, "R7 newer word kept", int'(rx_data), 8'hB1);
      chk(err_overrun == 1'b1, "R7 overrun set", int'(err_overrun), 1);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      chk({data_ready, err_overrun} == 2'b00, "R10 overrun cleared",
          int'({data_ready, err_overrun}), 0);
      chk(rx_data == 8'hB1, "R10 word kept after read", int'(rx_data), 8'hB1);

      chk(exp_q.size() == 0, "R9 all frames delivered", exp_q.size(), 0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule